// File: doc/BRIEF.md
# Path Remote Defect Indication Code Generator

This block produces the three-bit remote defect indication field that goes into the path status byte of the outgoing path overhead. Once per frame, on a single-cycle frame strobe, it looks at five path defect flags: alarm indication (AIS), loss of pointer (LOP), trace identifier mismatch (TIM), payload label mismatch (PLM) and unequipped (UNEQ). It drops any flag whose inhibit bit is set and turns what is left into a code. It then registers one stable value, which the overhead builder inserts for that frame.

Two encodings are offered. Legacy mode carries a single meaningful bit, the most significant one, which is driven by AIS or LOP. Enhanced mode separates server, connectivity and payload defects into distinct three-bit codes. Any code the hardware raises is held for a minimum number of frames, even when the defect that caused it clears sooner. A more severe code may replace a held one at any time, and doing so restarts the count. Software can override the output with its own three-bit code. The hardware hold state keeps running underneath that override.

Top module: `path_rdi_gen`

## Requirements
- R1: When `sw_ins_en` is 1 at a frame strobe, `rdi_code` takes the value of `sw_code` from the next clock on, whatever the defects are.
- R2: `rdi_code` changes only in the clock after a cycle in which `frame_tick` is 1, or after reset. Defect, mask and control changes between strobes have no visible effect.
- R3: With `enh_mode` = 0, the code is 3'b100 when an uninhibited AIS or LOP is present and 3'b000 otherwise. TIM, PLM and UNEQ have no effect in this mode.
- R4: With `enh_mode` = 1, the codes are: 3'b001 for no defect, 3'b010 for PLM, 3'b101 for AIS or LOP, and 3'b110 for TIM or UNEQ.
- R5: In enhanced mode, when several defects are present, server (101) wins over connectivity (110), and connectivity wins over payload (010).
- R6: Defect vector bit order is 0 = AIS, 1 = LOP, 2 = TIM, 3 = PLM, 4 = UNEQ. An `inhibit_mask` bit set to 1 removes the defect at the same position from the code.
- R7: A hardware code other than idle stays on `rdi_code` for at least HOLD_FRAMES (default 20) frame strobes, counting the strobe that raised it, even if its defect clears after the first frame.
- R8: A code of higher severity replaces a held code at once and restarts the hold count. A code of lower severity is taken only after the hold has expired.
- R9: Synchronous reset clears the hold count and sets `rdi_code` to the idle code of the current mode: 3'b001 in enhanced mode, 3'b000 in legacy mode.
- R10: The hold state keeps advancing while software insert is active. When `sw_ins_en` returns to 0, the next strobe shows the code still held by hardware.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_tick | input | 1 | One-cycle frame strobe |
| enh_mode | input | 1 | 1 = enhanced three-bit coding, 0 = legacy |
| sw_ins_en | input | 1 | Software code insert enable |
| sw_code | input | 3 | Software-supplied code |
| defects | input | 5 | Defect flags: 0 AIS, 1 LOP, 2 TIM, 3 PLM, 4 UNEQ |
| inhibit_mask | input | 5 | Per-defect inhibit, same bit order |
| rdi_code | output | 3 | Registered code for the path status byte bits 3:1 |

## Verification
The two functions that can act on the same frame strobe are the minimum-duration hold and the arrival of a different defect code. A defect of lower severity can be pending on the strobe where the hold expires. A defect of higher severity can also appear partway through a hold. The bench sets up both cases: it holds a server code while PLM is present, and it raises a server code while a payload code is being held. It then counts strobes and judges whether the new code appears on exactly the expected strobe and whether the restarted count ends on time. A software override that starts on the same strobe as a defect is also checked, to confirm that the hidden hold still lasts its full length.

// File: rtl/rdi_pkg.sv
package rdi_pkg;
    localparam int NUM_DEF = 5;
    localparam int D_AIS  = 0;
    localparam int D_LOP  = 1;
    localparam int D_TIM  = 2;
    localparam int D_PLM  = 3;
    localparam int D_UNEQ = 4;

    localparam logic [2:0] C_LEG_IDLE = 3'b000;
    localparam logic [2:0] C_LEG_RDI  = 3'b100;
    localparam logic [2:0] C_ENH_IDLE = 3'b001;
    localparam logic [2:0] C_ENH_PAY  = 3'b010;
    localparam logic [2:0] C_ENH_SRV  = 3'b101;
    localparam logic [2:0] C_ENH_CON  = 3'b110;

    // severity: 0 idle, 1 payload, 2 connectivity, 3 server
    function automatic logic [1:0] code_rank(input logic [2:0] c);
        case (c)
            C_LEG_RDI, C_ENH_SRV: code_rank = 2'd3;
            C_ENH_CON:            code_rank = 2'd2;
            C_ENH_PAY:            code_rank = 2'd1;
            default:              code_rank = 2'd0;
        endcase
    endfunction

    function automatic logic [2:0] idle_code(input logic enh);
        idle_code = enh ? C_ENH_IDLE : C_LEG_IDLE;
    endfunction
endpackage

// File: rtl/rdi_encoder.sv
module rdi_encoder
    import rdi_pkg::*;
(
    input  logic               enh_mode,
    input  logic [NUM_DEF-1:0] defects,
    input  logic [NUM_DEF-1:0] inhibit_mask,
    output logic [2:0]         raw_code
);
    logic [NUM_DEF-1:0] live;
    logic srv, con, pay;

    always_comb begin
        live = defects & ~inhibit_mask;
        srv  = live[D_AIS] | live[D_LOP];
        con  = live[D_TIM] | live[D_UNEQ];
        pay  = live[D_PLM];
        if (!enh_mode)  raw_code = srv ? C_LEG_RDI : C_LEG_IDLE;
        else if (srv)   raw_code = C_ENH_SRV;
        else if (con)   raw_code = C_ENH_CON;
        else if (pay)   raw_code = C_ENH_PAY;
        else            raw_code = C_ENH_IDLE;
    end
endmodule

// File: rtl/rdi_hold.sv
module rdi_hold
    import rdi_pkg::*;
#(
    parameter int HOLD_FRAMES = 20,
    localparam int CNT_W = $clog2(HOLD_FRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_tick,
    input  logic             enh_mode,
    input  logic [2:0]       raw_code,
    output logic [2:0]       code_next,
    output logic [2:0]       code_q,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] HOLD_LIM = CNT_W'(HOLD_FRAMES);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    typedef struct packed {
        logic [2:0]       code;
        logic [CNT_W-1:0] cnt;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic     hold_done;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d      = st_q;
        hold_done = (code_rank(st_q.code) == 2'd0) || (st_q.cnt >= HOLD_LIM);
        cnt_inc   = (st_q.cnt < HOLD_LIM) ? st_q.cnt + ONE : st_q.cnt;
        if (frame_tick) begin
            if (code_rank(raw_code) > code_rank(st_q.code)) begin
                st_d.code = raw_code;
                st_d.cnt  = ONE;
            end else if (raw_code == st_q.code) begin
                st_d.cnt = (code_rank(raw_code) == 2'd0) ? '0 : cnt_inc;
            end else if (hold_done) begin
                st_d.code = raw_code;
                st_d.cnt  = (code_rank(raw_code) == 2'd0) ? '0 : ONE;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.code <= idle_code(enh_mode);
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_next = st_d.code;
    assign code_q    = st_q.code;
    assign cnt_q     = st_q.cnt;
endmodule

// File: rtl/path_rdi_gen.sv
module path_rdi_gen
    import rdi_pkg::*;
#(
    parameter int HOLD_FRAMES = 20,
    localparam int CNT_W = $clog2(HOLD_FRAMES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_tick,
    input  logic               enh_mode,
    input  logic               sw_ins_en,
    input  logic [2:0]         sw_code,
    input  logic [NUM_DEF-1:0] defects,
    input  logic [NUM_DEF-1:0] inhibit_mask,
    output logic [2:0]         rdi_code
);
    typedef struct packed {
        logic [2:0] code;
    } out_st_t;

    logic [2:0]       raw_code;
    logic [2:0]       hold_next;
    logic [2:0]       hold_code;
    logic [CNT_W-1:0] hold_cnt;
    out_st_t          out_d, out_q;

    rdi_encoder u_enc (
        .enh_mode     (enh_mode),
        .defects      (defects),
        .inhibit_mask (inhibit_mask),
        .raw_code     (raw_code)
    );

    rdi_hold #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .enh_mode   (enh_mode),
        .raw_code   (raw_code),
        .code_next  (hold_next),
        .code_q     (hold_code),
        .cnt_q      (hold_cnt)
    );

    always_comb begin
        out_d = out_q;
        if (frame_tick)
            out_d.code = sw_ins_en ? sw_code : hold_next;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q.code <= idle_code(enh_mode);
        else     out_q <= out_d;
    end

    assign rdi_code = out_q.code;
endmodule

// File: rtl/path_rdi_chk.sv
module path_rdi_chk
    import rdi_pkg::*;
#(
    parameter int HOLD_FRAMES = 20,
    localparam int CNT_W = $clog2(HOLD_FRAMES + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_tick,
    input logic             enh_mode,
    input logic             sw_ins_en,
    input logic [2:0]       sw_code,
    input logic [2:0]       rdi_code,
    input logic [2:0]       hold_code,
    input logic [CNT_W-1:0] hold_cnt
);
    p_sw_override_r1: assert property (@(posedge clk) disable iff (rst)
        frame_tick && sw_ins_en |=> rdi_code == $past(sw_code));

    p_tick_only_r2: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> $stable(rdi_code));

    p_legacy_low_r3: assert property (@(posedge clk) disable iff (rst)
        frame_tick && !enh_mode && !sw_ins_en |=> rdi_code[1:0] == 2'b00);

    p_hold_rank_r7: assert property (@(posedge clk) disable iff (rst)
        frame_tick && hold_cnt != '0 && hold_cnt < CNT_W'(HOLD_FRAMES)
        |=> code_rank(hold_code) >= code_rank($past(hold_code)));

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
        hold_cnt <= CNT_W'(HOLD_FRAMES));

    p_reset_idle_r9: assert property (@(posedge clk)
        rst |=> rdi_code == idle_code($past(enh_mode)) && hold_cnt == '0);
endmodule

bind path_rdi_gen path_rdi_chk #(.HOLD_FRAMES(HOLD_FRAMES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_tick (frame_tick),
    .enh_mode   (enh_mode),
    .sw_ins_en  (sw_ins_en),
    .sw_code    (sw_code),
    .rdi_code   (rdi_code),
    .hold_code  (hold_code),
    .hold_cnt   (hold_cnt)
);

// File: tb/tb_path_rdi_gen.sv
module tb_path_rdi_gen;
    localparam time CLK_PERIOD = 10ns;
    localparam int  HOLD = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_tick = 1'b0;
    logic       enh_mode = 1'b1;
    logic       sw_ins_en = 1'b0;
    logic [2:0] sw_code = 3'b000;
    logic [4:0] defects = '0;
    logic [4:0] inhibit_mask = '0;
    logic [2:0] rdi_code;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bit order: 0 AIS, 1 LOP, 2 TIM, 3 PLM, 4 UNEQ
    localparam logic [4:0] AIS = 5'b00001, LOP = 5'b00010, TIM = 5'b00100,
                           PLM = 5'b01000, UNEQ = 5'b10000;

    always #(CLK_PERIOD/2) clk = ~clk;

    path_rdi_gen #(.HOLD_FRAMES(HOLD)) dut (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .enh_mode(enh_mode),
        .sw_ins_en(sw_ins_en), .sw_code(sw_code), .defects(defects),
        .inhibit_mask(inhibit_mask), .rdi_code(rdi_code)
    );

    task automatic chk(input string req, input logic [2:0] exp);
        n_chk++;
        if (rdi_code !== exp) begin
            n_fail++;
            $display("FAIL %s: rdi_code=%b expected=%b", req, rdi_code, exp);
        end
    endtask

    task automatic do_reset(input logic enh);
        @(negedge clk);
        enh_mode = enh; defects = '0; inhibit_mask = '0; sw_ins_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk) frame_tick = 1'b1;
        @(negedge clk) frame_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic t_reset();
        do_reset(1'b1); chk("R9 enhanced idle after reset", 3'b001);
        do_reset(1'b0); chk("R9 legacy idle after reset", 3'b000);
    endtask

    task automatic t_legacy();
        do_reset(1'b0);
        defects = TIM | PLM | UNEQ; tick(); chk("R3 legacy ignores TIM/PLM/UNEQ", 3'b000);
        defects = LOP; tick(); chk("R3 legacy LOP", 3'b100);
        do_reset(1'b0);
        defects = AIS; tick(); chk("R3 legacy AIS", 3'b100);
    endtask

    task automatic t_enh_codes();
        do_reset(1'b1); defects = PLM;  tick(); chk("R4 PLM payload", 3'b010);
        do_reset(1'b1); defects = TIM;  tick(); chk("R4 TIM connectivity", 3'b110);
        do_reset(1'b1); defects = UNEQ; tick(); chk("R4 UNEQ connectivity", 3'b110);
        do_reset(1'b1); defects = LOP;  tick(); chk("R4 LOP server", 3'b101);
        do_reset(1'b1); tick(); chk("R4 no defect", 3'b001);
    endtask

    task automatic t_priority();
        do_reset(1'b1); defects = '1; tick(); chk("R5 all defects -> server", 3'b101);
        do_reset(1'b1); defects = TIM | PLM; tick(); chk("R5 conn over payload", 3'b110);
    endtask

    task automatic t_mask();
        do_reset(1'b1); defects = AIS; inhibit_mask = AIS; tick();
        chk("R6 AIS inhibited", 3'b001);
        do_reset(1'b1); defects = AIS | LOP; inhibit_mask = AIS; tick();
        chk("R6 LOP survives AIS inhibit", 3'b101);
        do_reset(1'b1); defects = TIM | PLM; inhibit_mask = TIM; tick();
        chk("R6 TIM inhibited leaves PLM", 3'b010);
    endtask

    task automatic t_no_tick();
        do_reset(1'b1);
        defects = AIS; enh_mode = 1'b0; sw_ins_en = 1'b1; sw_code = 3'b111;
        repeat (5) @(negedge clk);
        chk("R2 stable without strobe", 3'b001);
    endtask

    task automatic t_hold();
        do_reset(1'b1);
        defects = AIS; tick(); defects = '0;
        ticks(HOLD - 1); chk("R7 held on last hold frame", 3'b101);
        tick(); chk("R7 released after hold", 3'b001);
    endtask

    task automatic t_preempt();
        do_reset(1'b1);
        defects = PLM; tick(); defects = '0; ticks(4);
        chk("R7 payload still held", 3'b010);
        defects = AIS; tick(); defects = '0;
        chk("R8 server preempts payload", 3'b101);
        ticks(HOLD - 1); chk("R8 restarted hold still on", 3'b101);
        tick(); chk("R8 restarted hold ends", 3'b001);
    endtask

    task automatic t_lower_waits();
        do_reset(1'b1);
        defects = AIS; tick(); defects = PLM;
        ticks(HOLD - 1); chk("R8 lower code waits for hold", 3'b101);
        tick(); chk("R8 lower code taken at expiry", 3'b010);
    endtask

    task automatic t_sw();
        do_reset(1'b1);
        sw_ins_en = 1'b1; sw_code = 3'b011; defects = AIS; tick();
        chk("R1 software code wins over AIS", 3'b011);
        defects = '0; ticks(2);
        sw_ins_en = 1'b0; tick();
        chk("R10 hardware hold kept under override", 3'b101);
        ticks(HOLD - 4); chk("R10 hold length unchanged", 3'b101);
        tick(); chk("R10 hold ends on time", 3'b001);
    endtask

    initial begin
        t_reset();
        t_legacy();
        t_enh_codes();
        t_priority();
        t_mask();
        t_no_tick();
        t_hold();
        t_preempt();
        t_lower_waits();
        t_sw();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule